// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This unit holds the two software-visible registers that steer and record floating-point arithmetic. A control register carries two trap-enable bits and a two-bit rounding selection, which is driven continuously to the arithmetic datapath. A status register keeps five sticky exception flags. Arithmetic results raise these flags through a flag strobe, and software reads them back over an auxiliary register bus.

Software can change the status flags directly only when bit 31 of the written word is set. That bit is a write qualifier. It is never stored and it always reads back as zero. A status write without the qualifier is dropped, so ordinary bus traffic cannot clear the recorded exceptions by accident. When an incoming invalid-operation or divide-by-zero flag meets a set enable bit, the unit issues a single-cycle trap request.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset, the control register (address 0x300) reads 0x00000100, the status register (address 0x301) reads 0x00000000, `round_mode_o` is 2'b01 and `trap_req_o` is 0.
- R2: A write to 0x300 stores only data bits 0 (invalid trap enable), 1 (divide-by-zero trap enable) and 9:8 (rounding). A read of the control register returns those bits and zero in every other bit position.
- R3: `round_mode_o` equals control bits 9:8 (00 toward zero, 01 nearest, 10 toward plus infinity, 11 toward minus infinity) from the cycle after the write that sets them.
- R4: A write to 0x301 whose data bit 31 is 1 replaces flags [4:0] with data bits [4:0]. Bit 0 is invalid, bit 1 divide by zero, bit 2 overflow, bit 3 underflow and bit 4 inexact. Status bit 31 and bits 30:5 always read as zero.
- R5: A write to 0x301 whose data bit 31 is 0 leaves the flags unchanged.
- R6: In each cycle with `dp_flag_vld` high, `dp_flags` is ORed into the status flags. When `dp_flag_vld` is low, `dp_flags` has no effect. Without a qualified write, no flag ever clears.
- R7: When a qualified status write and `dp_flag_vld` occur in the same cycle, the resulting flags are the written bits ORed with `dp_flags`.
- R8: `trap_req_o` is high in the cycle after a strobe exactly when (`dp_flags[0]` and control bit 0) or (`dp_flags[1]` and control bit 1). Otherwise it is low, so an isolated strobe produces a one-cycle pulse.
- R9: Writes to any address other than 0x300 and 0x301 change no register, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | 12 | Auxiliary register address for reads and writes |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dp_flag_vld | input | 1 | Datapath flag strobe |
| dp_flags | input | 5 | Datapath exception flags, same order as the status bits |
| round_mode_o | output | 2 | Rounding selection to the datapath |
| trap_req_o | output | 1 | Trap request pulse |

## Verification
The bench drives every incoming flag pattern under every pair of trap enables. A design that ORs in the wrong bits, or that decodes the trap from overflow, underflow or inexact, shows a wrong status value or a wrong pulse. It applies every pairing of qualified write data with a same-cycle datapath flag set. A design that lets either source win alone loses bits. It also writes status words with bit 31 cleared and reserved bits set. A design that ignores the qualifier clears flags, and one that stores bit 31 or the upper bits reads back nonzero. Every rounding and enable combination goes to the control register with reserved bits set, so a missing mask or a lagging rounding output shows up as a miscompare.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int XLEN   = 32;
  localparam int NFLAG  = 5;
  localparam int RM_LSB = 8;
  localparam int QUAL_BIT = 31;

  localparam int FLG_INV = 0;
  localparam int FLG_DZ  = 1;

  localparam logic [XLEN-1:0] CTRL_RESET = 32'h0000_0100;
  localparam logic [XLEN-1:0] CTRL_MASK  = 32'h0000_0303;

  typedef enum logic [1:0] {
    RND_ZERO = 2'b00,
    RND_NEAR = 2'b01,
    RND_POS  = 2'b10,
    RND_NEG  = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fpcsr_rst_sync.sv
module fpcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fpcsr_ctrl_reg.sv
module fpcsr_ctrl_reg
  import fpcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  input  logic            dp_flag_vld,
  input  logic [1:0]      dp_trap_flags,
  output logic [XLEN-1:0] ctrl_o,
  output rnd_mode_e       round_mode_o,
  output logic            trap_o
);
  logic [XLEN-1:0] ctrl_q, ctrl_d;
  logic            ctrl_en;
  logic            trap_q, trap_d;

  always_comb begin
    ctrl_en = wr_en;
    ctrl_d  = wdata & CTRL_MASK;
    trap_d  = dp_flag_vld &
              ((dp_trap_flags[FLG_INV] & ctrl_q[FLG_INV]) |
               (dp_trap_flags[FLG_DZ]  & ctrl_q[FLG_DZ]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign ctrl_o       = ctrl_q;
  assign round_mode_o = rnd_mode_e'(ctrl_q[RM_LSB+1:RM_LSB]);
  assign trap_o       = trap_q;

  // R3: rounding output follows the written field one cycle later
  p_round_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (round_mode_o == $past(wdata[RM_LSB+1:RM_LSB])));

  // R8: a trap pulse needs a strobe in the preceding cycle
  p_trap_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(dp_flag_vld));

  // R8: no trap when neither trapping flag arrived
  p_trap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_trap_flags == 2'b00) |=> !trap_o);
endmodule

// File: rtl/fpcsr_flag_reg.sv
module fpcsr_flag_reg
  import fpcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_qual,
  input  logic [NFLAG-1:0] wr_flags,
  input  logic             dp_flag_vld,
  input  logic [NFLAG-1:0] dp_flags,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] flags_q, flags_d, base;
  logic             sw_wr;
  logic             flags_en;

  always_comb begin
    sw_wr    = wr_en & wr_qual;
    base     = sw_wr ? wr_flags : flags_q;
    flags_d  = base | (dp_flag_vld ? dp_flags : '0);
    flags_en = sw_wr | dp_flag_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R4: a qualified write alone loads the written bits
  p_qual_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !dp_flag_vld) |=> (flags_o == $past(wr_flags)));

  // R5: without qualified write or strobe the flags hold
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !dp_flag_vld) |=> $stable(flags_o));

  // R6: flags only accumulate unless software overwrites them
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R7: coincident datapath flags survive a software write
  p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && dp_flag_vld) |=> ((flags_o & $past(dp_flags)) == $past(dp_flags)));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 12'h300,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 12'h301,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [XLEN-1:0]   bus_wdata,
  output logic [XLEN-1:0]   bus_rdata,
  input  logic              dp_flag_vld,
  input  logic [NFLAG-1:0]  dp_flags,
  output logic [1:0]        round_mode_o,
  output logic              trap_req_o
);
  logic            rst_n_s;
  logic            ctrl_sel, stat_sel;
  logic [XLEN-1:0] ctrl_val;
  logic [NFLAG-1:0] flag_val;
  rnd_mode_e       rnd;

  fpcsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    ctrl_sel = (bus_addr == CTRL_ADDR);
    stat_sel = (bus_addr == STAT_ADDR);
  end

  fpcsr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(bus_wr_en & ctrl_sel),
    .wdata(bus_wdata),
    .dp_flag_vld(dp_flag_vld),
    .dp_trap_flags(dp_flags[1:0]),
    .ctrl_o(ctrl_val),
    .round_mode_o(rnd),
    .trap_o(trap_req_o)
  );

  fpcsr_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(bus_wr_en & stat_sel),
    .wr_qual(bus_wdata[QUAL_BIT]),
    .wr_flags(bus_wdata[NFLAG-1:0]),
    .dp_flag_vld(dp_flag_vld),
    .dp_flags(dp_flags),
    .flags_o(flag_val)
  );

  assign round_mode_o = rnd;

  always_comb begin
    bus_rdata = '0;
    if (ctrl_sel)      bus_rdata = ctrl_val;
    else if (stat_sel) bus_rdata[NFLAG-1:0] = flag_val;
  end

  // R9: a write elsewhere leaves the control register untouched
  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(bus_wr_en && ctrl_sel)) |=> $stable(ctrl_val));
endmodule

// File: tb/fpcsr_unit_tb_top.sv
module fpcsr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dp_flag_vld;
  logic [4:0]  dp_flags;
  logic [1:0]  round_mode_o;
  logic        trap_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  fpcsr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_flag_vld(dp_flag_vld),
    .dp_flags(dp_flags), .round_mode_o(round_mode_o), .trap_req_o(trap_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic v, input logic [4:0] f);
    bus_wr_en = we; bus_addr = a; bus_wdata = d; dp_flag_vld = v; dp_flags = f;
    @(posedge clk);
    @(negedge clk);
    bus_wr_en = 1'b0; dp_flag_vld = 1'b0; dp_flags = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    bus_addr = a;
    #1;
    q = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic [4:0]  acc;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    dp_flag_vld = 1'b0; dp_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(12'h300, q); check("R1 ctrl", q, 32'h100);
    rd(12'h301, q); check("R1 status", q, 32'h0);
    check("R1 round", {30'b0, round_mode_o}, 32'h1);
    check("R1 trap", {31'b0, trap_req_o}, 32'h0);

    // R2, R3: every enable/rounding combination with reserved bits set
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = 32'hFFFF_FCFC | (32'(i >> 2) << 8) | 32'(i & 3);
      step(1'b1, 12'h300, d, 1'b0, 5'h0);
      rd(12'h300, q); check("R2 ctrl mask", q, d & 32'h303);
      check("R3 round", {30'b0, round_mode_o}, 32'(i >> 2));
    end

    // R9: foreign address neither written nor read
    step(1'b1, 12'h300, 32'h0000_0201, 1'b0, 5'h0);
    step(1'b1, 12'h302, 32'hFFFF_FFFF, 1'b0, 5'h0);
    step(1'b1, 12'h2FF, 32'hFFFF_FFFF, 1'b0, 5'h0);
    rd(12'h300, q); check("R9 ctrl kept", q, 32'h201);
    rd(12'h301, q); check("R9 status kept", q, 32'h0);
    rd(12'h302, q); check("R9 read zero", q, 32'h0);
    rd(12'h000, q); check("R9 read zero", q, 32'h0);

    // R4..R8: every flag pattern under every enable pair
    for (int en = 0; en < 4; en++) begin
      step(1'b1, 12'h300, 32'h100 | 32'(en), 1'b0, 5'h0);
      for (int f = 0; f < 32; f++) begin
        logic [4:0] fv;
        fv = 5'(f);
        step(1'b1, 12'h301, 32'h8000_0000, 1'b0, 5'h0);
        rd(12'h301, q); check("R4 clear", q, 32'h0);
        step(1'b0, 12'h301, 32'h0, 1'b1, fv);
        rd(12'h301, q); check("R6 or-in", q, 32'(fv));
        check("R8 trap", {31'b0, trap_req_o},
              32'(((fv[0] & en[0]) | (fv[1] & en[1]))));
        step(1'b0, 12'h301, 32'h0, 1'b0, 5'h1F);
        check("R8 pulse end", {31'b0, trap_req_o}, 32'h0);
        rd(12'h301, q); check("R6 strobe low ignored", q, 32'(fv));
        step(1'b1, 12'h301, 32'h7FFF_FFE0, 1'b0, 5'h0);
        rd(12'h301, q); check("R5 unqualified", q, 32'(fv));
      end
    end

    // R4: direct loads with junk in reserved bits
    for (int v = 0; v < 32; v++) begin
      step(1'b1, 12'h301, 32'hFFFF_FFE0 | 32'(v), 1'b0, 5'h0);
      rd(12'h301, q); check("R4 load", q, 32'(v));
    end

    // R6 accumulation
    step(1'b1, 12'h301, 32'h8000_0000, 1'b0, 5'h0);
    acc = '0;
    for (int b = 0; b < 5; b++) begin
      step(1'b0, 12'h301, 32'h0, 1'b1, 5'(1 << b));
      acc = acc | 5'(1 << b);
      rd(12'h301, q); check("R6 accumulate", q, 32'(acc));
    end

    // R7: every write/strobe pairing in one cycle
    for (int w = 0; w < 32; w++) begin
      for (int d = 0; d < 32; d++) begin
        step(1'b1, 12'h301, 32'h8000_0000 | 32'(w), 1'b1, 5'(d));
        rd(12'h301, q); check("R7 merge", q, 32'(w | d));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule